// File: doc/BRIEF.md
# Host FIFO DMA Handshake with Burst Read

This block sits between a host bus and a 16-bit data FIFO. The FIFO is seen by the host as two byte lanes: the A half travels on the upper lane and the B half on the lower lane. A transfer counter is loaded with a number of bytes. A DMA request is raised while the counter is non-zero and the FIFO can take part in a transfer in the selected direction. Host strobes are honoured only while the active-low acknowledge is held, and no address decode is involved. A FIFO word moves on the rising edge of the read or write strobe.

Narrow (8-bit) accesses use only the lower lane. They step through the A half and then the B half of each word. In burst-read mode the head word is driven on the host bus at all times, and every rising edge of the read strobe removes a word. The acknowledge is not needed in that mode. The side of the chip that fills or drains the FIFO is represented by a plain push port and a plain pop port.

Top module: `host_dma_fifo`

## Requirements
- R1: After synchronous reset the request is low, the byte counter is 0 and the FIFO is empty.
- R2: The request is high while the counter is non-zero and the FIFO holds a word (host-read direction, `cfg_dir_rd`=1) or has a free slot (host-write direction, `cfg_dir_rd`=0).
- R3: The request is low whenever the counter is 0, including right after the final transfer brings it to 0.
- R4: The request drops when the FIFO becomes empty in the read direction, or full in the write direction.
- R5: A load sets the counter. Each accepted transfer reduces it by 2 for a word access and by 1 for a byte access. It saturates at 0 and never wraps.
- R6: In a 16-bit DMA read, while the acknowledge and the read strobe are both low, `host_dout` shows the head word with A in bits 15:8 and B in bits 7:0. The word is popped on the rising edge of the read strobe.
- R7: In a 16-bit DMA write, `host_din` is captured on the rising edge of the write strobe. Bits 15:8 go to the A half and bits 7:0 to the B half.
- R8: When burst mode is off, strobes seen while the acknowledge is high are ignored. The FIFO, the counter and the read data are left unchanged.
- R9: With `cfg_wide`=0, only bits 7:0 carry data and the upper lane reads 0. The A byte comes first and the B byte second. A word is popped, or pushed with A from the first byte, only when its B byte is transferred. A counter load restarts the sequence at A.
- R10: In burst mode (read direction), `host_dout` always shows the head word, or 0 when the FIFO is empty. Each rising edge of the read strobe pops one word and reduces the counter by 2, with no acknowledge required.
- R11: `burst_rdy` is high when at least one word is stored (read direction) or at least one slot is free (write direction).
- R12: A strobe edge is ignored when the counter is 0 or the FIFO is empty (read) or full (write). The stored words and the counter stay unchanged.
- R13: `side_push` has an effect only in the read direction and `side_pop` only in the write direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dir_rd | input | 1 | 1: host reads from the FIFO; 0: host writes into it |
| cfg_wide | input | 1 | 1: 16-bit accesses; 0: 8-bit accesses on the lower lane |
| cfg_burst | input | 1 | Burst-read mode enable |
| cnt_load | input | 1 | Load the byte counter |
| cnt_value | input | CNT_W | Value to load |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 16 | Host write data (A upper, B lower) |
| host_dout | output | 16 | Host read data (A upper, B lower) |
| drq | output | 1 | DMA request |
| burst_rdy | output | 1 | FIFO ready for a burst access |
| xfer_left | output | CNT_W | Bytes still to transfer |
| side_push | input | 1 | Push from the bus side (read direction) |
| side_din | input | 16 | Data for side push |
| side_pop | input | 1 | Pop toward the bus side (write direction) |
| side_dout | output | 16 | Head word toward the bus side |
| side_full | output | 1 | FIFO full |
| side_empty | output | 1 | FIFO empty |

## Verification
The bench checks that the request falls for each of its two separate reasons: the counter reaching zero, and the FIFO running dry or filling up. A design that combined only one of these would keep requesting cycles it cannot serve. Byte mode is checked for lane order and for the moment the pop or push happens. A design that popped after the A byte would lose the B byte, and one that swapped halves would return the bytes reversed. The bench also loads the counter with an odd value of 1 before a word transfer, which exposes a counter that wraps to a large value instead of stopping at zero. Finally, strobes given with the acknowledge high, or against a full FIFO, must leave the stored data untouched. A design that accepted them would let a later read return the wrong word.

// File: rtl/hdf_pkg.sv
package hdf_pkg;

    localparam int LANE_W = 8;

    typedef struct packed {
        logic [LANE_W-1:0] a;   // upper lane
        logic [LANE_W-1:0] b;   // lower lane
    } lanes_t;

    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;

    // bytes consumed by one accepted access
    function automatic logic [1:0] access_bytes(input logic word_access);
        return word_access ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/hdf_edge.sv
module hdf_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise
);
    logic prev_n;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= 1'b1;
        else     prev_n <= strobe_n;
    end

    assign rise = strobe_n & ~prev_n;
endmodule

// File: rtl/hdf_fifo.sv
module hdf_fifo
    import hdf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  lanes_t din,
    input  logic   pop,
    output lanes_t head,
    output logic   full,
    output logic   empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lanes_t        mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   fill;
    logic          do_push, do_pop;

    assign full    = (fill == (AW+1)'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/hdf_counter.sv
module hdf_counter
    import hdf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             dec_word,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    logic [CNT_W-1:0] step;

    assign step = CNT_W'(access_bytes(dec_word));
    assign zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= (count < step) ? '0 : count - step;
    end
endmodule

// File: rtl/host_dma_fifo.sv
module host_dma_fifo
    import hdf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dir_rd,
    input  logic             cfg_wide,
    input  logic             cfg_burst,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             dack_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [15:0]      host_din,
    output logic [15:0]      host_dout,
    output logic             drq,
    output logic             burst_rdy,
    output logic [CNT_W-1:0] xfer_left,
    input  logic             side_push,
    input  logic [15:0]      side_din,
    input  logic             side_pop,
    output logic [15:0]      side_dout,
    output logic             side_full,
    output logic             side_empty
);
    localparam int NSTROBE = 2;   // index 0: read, 1: write

    logic [NSTROBE-1:0] strobe_n, rise;
    lanes_t             head, fifo_din;
    logic               full, empty, cnt_zero;
    logic               fifo_push, fifo_pop;
    logic               rd_take, wr_take, rd_byte, wr_byte;
    logic               host_pop, host_push;
    half_e              half;
    logic [LANE_W-1:0]  hold_a;

    assign strobe_n = {wr_n, rd_n};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_edge
        hdf_edge u_edge (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (strobe_n[g]),
            .rise     (rise[g])
        );
    end

    // access qualification
    assign rd_byte = ~cfg_wide & ~cfg_burst;
    assign wr_byte = ~cfg_wide;
    assign rd_take = rise[0] & ~cnt_zero & cfg_dir_rd & ~empty
                   & (cfg_burst | ~dack_n);
    assign wr_take = rise[1] & ~cnt_zero & ~cfg_dir_rd & ~full & ~dack_n;

    assign host_pop  = rd_take & (~rd_byte | (half == HALF_B));
    assign host_push = wr_take & (~wr_byte | (half == HALF_B));

    always_ff @(posedge clk) begin
        if (rst) begin
            half   <= HALF_A;
            hold_a <= '0;
        end else if (cnt_load) begin
            half <= HALF_A;
        end else if ((rd_take & rd_byte) | (wr_take & wr_byte)) begin
            half <= (half == HALF_A) ? HALF_B : HALF_A;
            if (wr_take && half == HALF_A)
                hold_a <= host_din[LANE_W-1:0];
        end
    end

    // FIFO source and sink by direction
    always_comb begin
        if (cfg_dir_rd)
            fifo_din = lanes_t'(side_din);
        else if (wr_byte)
            fifo_din = '{a: hold_a, b: host_din[LANE_W-1:0]};
        else
            fifo_din = lanes_t'(host_din);
    end

    assign fifo_push = cfg_dir_rd ? side_push : host_push;
    assign fifo_pop  = cfg_dir_rd ? host_pop  : side_pop;

    hdf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    hdf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_value),
        .dec      (rd_take | wr_take),
        .dec_word (rd_take ? ~rd_byte : ~wr_byte),
        .count    (xfer_left),
        .zero     (cnt_zero)
    );

    // host read data
    always_comb begin
        host_dout = '0;
        if (cfg_dir_rd && !empty) begin
            if (cfg_burst)
                host_dout = head;
            else if (!dack_n && !rd_n)
                host_dout = cfg_wide ? 16'(head)
                                     : {8'h00, (half == HALF_B) ? head.b : head.a};
        end
    end

    assign burst_rdy  = cfg_dir_rd ? ~empty : ~full;
    assign drq        = ~cnt_zero & burst_rdy;
    assign side_dout  = head;
    assign side_full  = full;
    assign side_empty = empty;
endmodule

// File: rtl/hdf_checker.sv
module hdf_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_dir_rd,
    input logic             cnt_load,
    input logic             drq,
    input logic             burst_rdy,
    input logic [CNT_W-1:0] xfer_left,
    input logic             side_full,
    input logic             side_empty
);
    a_r3_zero_blocks_request: assert property (@(posedge clk) disable iff (rst)
        (xfer_left == '0) |-> !drq);

    a_r4_empty_blocks_request: assert property (@(posedge clk) disable iff (rst)
        (cfg_dir_rd && side_empty) |-> !drq);

    a_r4_full_blocks_request: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir_rd && side_full) |-> !drq);

    a_r5_count_never_rises: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> (xfer_left <= $past(xfer_left)));

    a_r5_step_at_most_two: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> (($past(xfer_left) - xfer_left) <= CNT_W'(2)));

    a_r11_request_implies_ready: assert property (@(posedge clk) disable iff (rst)
        drq |-> burst_rdy);
endmodule

bind host_dma_fifo hdf_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_dir_rd (cfg_dir_rd),
    .cnt_load   (cnt_load),
    .drq        (drq),
    .burst_rdy  (burst_rdy),
    .xfer_left  (xfer_left),
    .side_full  (side_full),
    .side_empty (side_empty)
);

// File: tb/host_dma_fifo_tb_top.sv
`timescale 1ns/1ps
module host_dma_fifo_tb_top;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_dir_rd = 1'b1, cfg_wide = 1'b1, cfg_burst = 1'b0;
    logic cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] host_din = '0, host_dout;
    logic drq, burst_rdy;
    logic [CNT_W-1:0] xfer_left;
    logic side_push = 1'b0, side_pop = 1'b0;
    logic [15:0] side_din = '0, side_dout;
    logic side_full, side_empty;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    host_dma_fifo #(.DEPTH(4), .CNT_W(CNT_W)) dut_i (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_cnt(input int v);
        cnt_load = 1'b1; cnt_value = CNT_W'(v);
        tick();
        cnt_load = 1'b0;
    endtask

    task automatic push_side(input logic [15:0] w);
        side_push = 1'b1; side_din = w;
        tick();
        side_push = 1'b0;
    endtask

    task automatic pop_side();
        side_pop = 1'b1;
        tick();
        side_pop = 1'b0;
    endtask

    task automatic host_read(input logic ack_n, output logic [15:0] d);
        dack_n = ack_n; rd_n = 1'b0;
        tick();
        d = host_dout;
        rd_n = 1'b1;
        tick();
        dack_n = 1'b1;
    endtask

    task automatic host_write(input logic ack_n, input logic [15:0] d);
        dack_n = ack_n; wr_n = 1'b0; host_din = d;
        tick();
        wr_n = 1'b1;
        tick();
        dack_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1", "drq", 32'(drq), 32'd0);
        check("R1", "count", 32'(xfer_left), 32'd0);
        check("R1", "empty", 32'(side_empty), 32'd1);
        check("R11", "burst_rdy read dir empty", 32'(burst_rdy), 32'd0);
        cfg_dir_rd = 1'b0; #1;
        check("R11", "burst_rdy write dir empty", 32'(burst_rdy), 32'd1);
        check("R3", "drq with zero count", 32'(drq), 32'd0);
        cfg_dir_rd = 1'b1; #1;
    endtask

    task automatic t_dma_read16();
        push_side(16'hA1B2);
        push_side(16'hC3D4);
        check("R3", "drq zero count with data", 32'(drq), 32'd0);
        load_cnt(4);
        check("R2", "drq after load", 32'(drq), 32'd1);
        host_read(1'b0, rdata);
        check("R6", "first word lanes", 32'(rdata), 32'hA1B2);
        check("R5", "count after word", 32'(xfer_left), 32'd2);
        host_read(1'b0, rdata);
        check("R6", "second word", 32'(rdata), 32'hC3D4);
        check("R3", "drq at count zero", 32'(drq), 32'd0);
        check("R6", "popped to empty", 32'(side_empty), 32'd1);
    endtask

    task automatic t_empty_drop();
        load_cnt(10);
        push_side(16'h5566);
        check("R2", "drq with word", 32'(drq), 32'd1);
        host_read(1'b0, rdata);
        check("R6", "word", 32'(rdata), 32'h5566);
        check("R4", "drq on empty", 32'(drq), 32'd0);
        host_read(1'b0, rdata);
        check("R12", "count unchanged on empty read", 32'(xfer_left), 32'd8);
    endtask

    task automatic t_dack_ignored();
        push_side(16'h1234);
        host_read(1'b1, rdata);
        check("R8", "count with dack high", 32'(xfer_left), 32'd8);
        check("R8", "no data with dack high", 32'(rdata), 32'h0000);
        check("R8", "fifo kept word", 32'(side_empty), 32'd0);
        host_read(1'b0, rdata);
        check("R8", "word after ignored strobe", 32'(rdata), 32'h1234);
    endtask

    task automatic t_side_rules();
        pop_side();
        check("R13", "side pop ignored in read dir", 32'(xfer_left), 32'd6);
        cfg_dir_rd = 1'b0;
        push_side(16'hFFFF);
        check("R13", "side push ignored in write dir", 32'(side_empty), 32'd1);
    endtask

    task automatic t_write16();
        load_cnt(20);
        host_write(1'b0, 16'h5A6B);
        check("R7", "captured word", 32'(side_dout), 32'h5A6B);
        check("R5", "count after write", 32'(xfer_left), 32'd18);
        pop_side();
        for (int i = 1; i <= 4; i++) host_write(1'b0, {8'(i), 8'(i)});
        check("R4", "full", 32'(side_full), 32'd1);
        check("R4", "drq on full", 32'(drq), 32'd0);
        host_write(1'b0, 16'h0505);
        check("R12", "count on full write", 32'(xfer_left), 32'd10);
        check("R12", "head intact", 32'(side_dout), 32'h0101);
        for (int i = 0; i < 4; i++) pop_side();
        check("R2", "drq write dir with room", 32'(drq), 32'd1);
    endtask

    task automatic t_byte_mode();
        cfg_dir_rd = 1'b1; cfg_wide = 1'b0;
        load_cnt(3);
        push_side(16'h9C7E);
        host_read(1'b0, rdata);
        check("R9", "A byte first", 32'(rdata), 32'h009C);
        check("R5", "byte decrement", 32'(xfer_left), 32'd2);
        check("R9", "word kept after A", 32'(side_empty), 32'd0);
        host_read(1'b0, rdata);
        check("R9", "B byte second", 32'(rdata), 32'h007E);
        check("R9", "popped after B", 32'(side_empty), 32'd1);
        cfg_dir_rd = 1'b0;
        load_cnt(2);
        host_write(1'b0, 16'h0011);
        check("R9", "no push after A", 32'(side_empty), 32'd1);
        host_write(1'b0, 16'h0022);
        check("R9", "assembled word", 32'(side_dout), 32'h1122);
        check("R5", "count to zero", 32'(xfer_left), 32'd0);
        pop_side();
    endtask

    task automatic t_saturate();
        cfg_dir_rd = 1'b1; cfg_wide = 1'b1;
        load_cnt(1);
        push_side(16'hBEEF);
        host_read(1'b0, rdata);
        check("R6", "word", 32'(rdata), 32'hBEEF);
        check("R5", "saturates at zero", 32'(xfer_left), 32'd0);
    endtask

    task automatic t_burst();
        cfg_burst = 1'b1;
        load_cnt(6);
        push_side(16'h1111);
        push_side(16'h2222);
        push_side(16'h3333);
        check("R10", "head driven idle", 32'(host_dout), 32'h1111);
        check("R11", "ready with data", 32'(burst_rdy), 32'd1);
        host_read(1'b1, rdata);
        check("R10", "next head after pop", 32'(host_dout), 32'h2222);
        check("R10", "count per burst pop", 32'(xfer_left), 32'd4);
        host_read(1'b1, rdata);
        host_read(1'b1, rdata);
        check("R10", "last word seen", 32'(rdata), 32'h3333);
        check("R10", "bus zero when empty", 32'(host_dout), 32'h0000);
        check("R11", "not ready when empty", 32'(burst_rdy), 32'd0);
        cfg_burst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_dma_read16();
        t_empty_drop();
        t_dack_ignored();
        t_side_rules();
        t_write16();
        t_byte_mode();
        t_saturate();
        t_burst();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule